// File: doc/BRIEF.md
# Static Segment Approximate Multiplier

This block multiplies two unsigned 16-bit operands and returns an approximate 32-bit product. It does not build a full 16x16 array. For each operand it keeps a single 8-bit segment. A plain OR test on the operand's high byte decides which segment to keep: if any high bit is set, the high byte is kept and the low byte is dropped. Otherwise the low byte is kept. The two kept segments go through an exact 8x8 core. That core is built from per-bit selection of shifted multiplicand copies and a summing tree. The 16-bit result is then shifted back into position by 8 bits for each operand that used its high byte.

The result is exact whenever both operands fit in a byte. The error grows only with the low bits that a large operand discards. This suits error-tolerant pixel and filter arithmetic, where a small multiplier is worth more than the last few low-order product bits. A request is accepted with a one-cycle valid strobe, and the registered product appears with its own valid flag one clock later.

Top module: `seg_approx_mul`

## Requirements
- R1: A synchronous active-high reset drives `out_product` to 0 and `out_valid` to 0 on the clock edge where `rst` is sampled high.
- R2: When bits 15:8 of both operands are all zero, the low bytes are used with no shift, so the product equals the exact product (0x00FF x 0x00FF gives 0x0000FE01).
- R3: When an operand has any bit set in 15:8, its segment is bits 15:8 and bits 7:0 of that operand have no effect on the product (0x01FF x 0x0003 gives 0x00000300).
- R4: When exactly one operand uses its high byte, the 16-bit segment product is shifted left by 8 (0x55FF x 0x00FF gives 5548800).
- R5: When both operands use their high bytes, the segment product is shifted left by 16, so product bits 15:0 are zero (0xFFFF x 0xFFFF gives 0xFE010000).
- R6: A zero operand yields a zero product, whatever the other operand is.
- R7: `out_valid` is high in exactly the cycle after an accepted `in_valid`, and is low otherwise. `out_product` holds its value while no request is accepted.
- R8: The 8x8 segment core returns the exact product of its two bytes for every byte pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| op_a | input | 16 | Unsigned operand A |
| op_b | input | 16 | Unsigned operand B |
| out_valid | output | 1 | High for the one cycle after an accepted request |
| out_product | output | 32 | Registered approximate product |

## Verification
The hardest case to reach from the ports is one where the discarded low byte would have changed the answer. The high byte must be nonzero while the low byte is full, and the two operands must fall into different segment classes, so that each shift amount is seen. Plain random 16-bit operands almost never have a zero high byte, so the random stream masks each operand to a byte with a fixed probability. The directed table then pins operands right at the class border: 0x00FF next to 0x0100, and 0xFFFF against small and zero partners.

// File: rtl/sam_pkg.sv
package sam_pkg;
  // Default operand and segment sizes
  localparam int OP_W_DEF  = 16;
  localparam int SEG_W_DEF = 8;

  // How many operands contributed their upper segment
  typedef enum logic [1:0] {
    SCALE_NONE = 2'd0,
    SCALE_ONE  = 2'd1,
    SCALE_TWO  = 2'd2
  } scale_e;

  function automatic scale_e scale_of(input logic hi_a, input logic hi_b);
    unique case ({hi_a, hi_b})
      2'b00:   return SCALE_NONE;
      2'b11:   return SCALE_TWO;
      default: return SCALE_ONE;
    endcase
  endfunction
endpackage

// File: rtl/sam_seg_pick.sv
module sam_seg_pick #(
  parameter int OP_W  = sam_pkg::OP_W_DEF,
  parameter int SEG_W = sam_pkg::SEG_W_DEF
) (
  input  logic [OP_W-1:0]  op,
  output logic [SEG_W-1:0] seg,
  output logic             hi_used
);
  localparam int HI_W = OP_W - SEG_W;

  // OR test over the bits above the low segment
  assign hi_used = |op[OP_W-1:SEG_W];

  always_comb begin
    if (hi_used) seg = op[OP_W-1 -: SEG_W];
    else         seg = op[SEG_W-1:0];
  end

  // R6
  always_comb begin
    seg_nonzero_chk: assert ((op == '0) || (seg != '0))
      else $error("nonzero operand produced a zero segment");
  end
endmodule

// File: rtl/sam_mux_core.sv
module sam_mux_core #(
  parameter int SEG_W = sam_pkg::SEG_W_DEF
) (
  input  logic [SEG_W-1:0]   mcand,
  input  logic [SEG_W-1:0]   ctrl,
  output logic [2*SEG_W-1:0] prod
);
  localparam int MID_W = 2 * SEG_W;

  logic [MID_W-1:0] term [SEG_W];

  // One selected term per control bit: shifted multiplicand or zero
  for (genvar i = 0; i < SEG_W; i++) begin : g_term
    assign term[i] = ctrl[i] ? (MID_W'(mcand) << i) : '0;
  end

  always_comb begin
    logic [MID_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SEG_W; i++) acc = acc + term[i];
    prod = acc;
  end

  // R8
  always_comb begin
    core_exact_chk: assert (prod == MID_W'(mcand) * MID_W'(ctrl))
      else $error("segment core product mismatch");
  end
endmodule

// File: rtl/sam_rescale.sv
module sam_rescale #(
  parameter int OP_W  = sam_pkg::OP_W_DEF,
  parameter int SEG_W = sam_pkg::SEG_W_DEF
) (
  input  logic [2*SEG_W-1:0] mid,
  input  sam_pkg::scale_e    scale,
  output logic [2*OP_W-1:0]  full
);
  localparam int PROD_W = 2 * OP_W;
  localparam int STEP   = OP_W - SEG_W;

  logic [PROD_W-1:0] ext;
  assign ext = PROD_W'(mid);

  always_comb begin
    unique case (scale)
      sam_pkg::SCALE_NONE: full = ext;
      sam_pkg::SCALE_ONE:  full = ext << STEP;
      sam_pkg::SCALE_TWO:  full = ext << (2 * STEP);
      default:             full = '0;
    endcase
  end
endmodule

// File: rtl/seg_approx_mul.sv
module seg_approx_mul #(
  parameter int OP_W  = sam_pkg::OP_W_DEF,
  parameter int SEG_W = sam_pkg::SEG_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [OP_W-1:0]    op_a,
  input  logic [OP_W-1:0]    op_b,
  output logic               out_valid,
  output logic [2*OP_W-1:0]  out_product
);
  localparam int PROD_W = 2 * OP_W;
  localparam int MID_W  = 2 * SEG_W;
  localparam int HI_W   = OP_W - SEG_W;

  logic [SEG_W-1:0]  seg_a, seg_b;
  logic              hi_a, hi_b;
  logic [MID_W-1:0]  mid;
  logic [PROD_W-1:0] approx;
  sam_pkg::scale_e   scale;

  sam_seg_pick #(.OP_W(OP_W), .SEG_W(SEG_W)) u_pick_a (
    .op(op_a), .seg(seg_a), .hi_used(hi_a));
  sam_seg_pick #(.OP_W(OP_W), .SEG_W(SEG_W)) u_pick_b (
    .op(op_b), .seg(seg_b), .hi_used(hi_b));

  sam_mux_core #(.SEG_W(SEG_W)) u_core (
    .mcand(seg_a), .ctrl(seg_b), .prod(mid));

  assign scale = sam_pkg::scale_of(hi_a, hi_b);

  sam_rescale #(.OP_W(OP_W), .SEG_W(SEG_W)) u_scale (
    .mid(mid), .scale(scale), .full(approx));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_product <= approx;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_product == '0));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_product)));

  // R6
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_a == '0 || op_b == '0)) |=> out_product == '0);

  // R2
  small_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a[OP_W-1:SEG_W] == '0 && op_b[OP_W-1:SEG_W] == '0)
    |=> out_product == PROD_W'($past(op_a)) * PROD_W'($past(op_b)));

  // R5
  both_high_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a[OP_W-1:SEG_W] != '0 && op_b[OP_W-1:SEG_W] != '0)
    |=> out_product[2*HI_W-1:0] == '0);
endmodule

// File: tb/sim_seg_approx_mul.sv
module sim_seg_approx_mul;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {op_a, op_b, expected product}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'h55FF, 16'h00FF, 32'h0054AB00},
    {16'h00FF, 16'h00FF, 32'h0000FE01},
    {16'hFFFF, 16'hFFFF, 32'hFE010000},
    {16'h0100, 16'h00FF, 32'h0000FF00},
    {16'h0100, 16'h0100, 32'h00010000},
    {16'h0000, 16'hFFFF, 32'h00000000},
    {16'hFFFF, 16'h0000, 32'h00000000},
    {16'h01FF, 16'h0003, 32'h00000300},
    {16'h8000, 16'h0002, 32'h00010000},
    {16'h1234, 16'h0056, 32'h00060C00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] out_product;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_approx_mul u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_product(out_product));

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic [7:0] sa, sb;
    int sh;
    sh = 0;
    if (a[15:8] != 0) begin sa = a[15:8]; sh += 8; end else sa = a[7:0];
    if (b[15:8] != 0) begin sb = b[15:8]; sh += 8; end else sb = b[7:0];
    return (32'(sa) * 32'(sb)) << sh;
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic [15:0] b);
    if (a == 0 || b == 0) return "R6";
    if (a[15:8] != 0 && b[15:8] != 0) return "R5";
    if (a[15:8] != 0 || b[15:8] != 0) return "R4";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One request; checks the product and valid one cycle later, then idle hold
  task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                        input logic [31:0] exp, input string req);
    logic [31:0] held;
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    op_a = ~a; op_b = ~b;
    check("R7", 32'(out_valid), 32'd1);
    check(req, out_product, exp);
    held = out_product;
    @(negedge clk);
    check("R7", 32'(out_valid), 32'd0);
    check("R7", out_product, held);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset clears even with a request present
    in_valid = 1'b1; op_a = 16'hFFFF; op_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1", 32'(out_valid), 32'd0);
    check("R1", out_product, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][63:48], VEC[i][47:32], VEC[i][31:0],
             tag_of(VEC[i][63:48], VEC[i][47:32]));
    end

    // R3: low byte of a wide operand has no effect
    run_op(16'h0100, 16'h0003, 32'h00000300, "R3");
    run_op(16'h01AA, 16'h0003, 32'h00000300, "R3");

    // R8 through the ports: small operands sweep the core exactly
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a, b;
      a = 16'(i * 17); b = 16'(255 - i * 13);
      run_op(a, b, 32'(a) * 32'(b), "R8");
    end

    // Random stream, each operand masked to a byte half the time
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom % 2 == 0) a = a & 16'h00FF;
      if ($urandom % 2 == 0) b = b & 16'h00FF;
      if ($urandom % 16 == 0) a = 16'h0000;
      run_op(a, b, ref_mul(a, b), tag_of(a, b));
    end

    // R1: reset mid-stream clears a held product
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", out_product, 32'd0);
    check("R1", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule